// File: doc/BRIEF.md
# Operand-Addressing Byte Decoder

This block sits behind an instruction fetch stage. It takes over once the opcode is known to carry an operand-addressing byte. A one-cycle `start` pulse latches the address mode and the three prefix extension bits. The block then pulls bytes from a valid/ready stream. It reads the addressing byte first, then an optional scaled-index byte, then zero to four displacement bytes. The number of bytes it reads depends on what the earlier bytes contained.

The block splits out the fields and extends the register numbers to 4 bits with the prefix bits. It assembles the displacement and sign-extends it when it is a single byte. It also reports how many displacement bytes there were and how many bytes it consumed in total. A single-cycle `done` pulse marks that the outputs are complete. The outputs hold their values until the next `start`.

The controller has four states:

- `ST_IDLE` waits for `start`, and the `start` transition moves it to `ST_MODRM`.
- `ST_MODRM` accepts the addressing byte. It then moves to `ST_SIB` if an index byte follows, or to `ST_DISP` if displacement bytes follow. Otherwise it finishes and returns to `ST_IDLE`.
- `ST_SIB` accepts the index byte. It then moves to `ST_DISP` or finishes.
- `ST_DISP` accepts displacement bytes and finishes on the last one.

Every finish returns to `ST_IDLE` and raises `done` on the next cycle.

Top module: `modrm_decoder`

## Requirements
- R1: The first byte is split with `mod_f` = bits 7:6, the low three bits of `reg_f` = bits 5:3 and the low three bits of `rm_f` = bits 2:0. `is_reg` is 1 exactly when `mod_f` = 3.
- R2: In 16-bit mode (`addr_mode` = 0), the displacement length is set by `mod_f` and `rm_f`. With `mod_f` = 0 it is 2 bytes when `rm_f` = 6 and 0 bytes otherwise. `mod_f` = 1 gives 1 byte, `mod_f` = 2 gives 2 bytes and `mod_f` = 3 gives none. No index byte is ever read in this mode.
- R3: In 32-bit mode, `mod_f` = 0 with `rm_f` = 5 gives a 4-byte displacement and no index byte. Otherwise `mod_f` = 1 gives 1 byte, `mod_f` = 2 gives 4 bytes, and `mod_f` = 0 or 3 gives none.
- R4: In 32-bit mode, `rex_r` becomes bit 3 of `reg_f`. `rex_b` becomes bit 3 of `rm_f` when `mod_f` = 3. It also does so when `mod_f` ≠ 3 and there is neither an index byte nor the `mod_f` = 0/`rm_f` = 5 form. In 16-bit mode both bit 3 positions are 0.
- R5: In 32-bit mode, an index byte follows when `mod_f` ≠ 3 and `rm_f` = 4. Its fields are split as `sib_scale` = bits 7:6, `sib_index` = {`rex_x`, bits 5:3} and `sib_base` = {`rex_b`, bits 2:0}. `rm_f` stays 4 in that case.
- R6: When the 4-bit `sib_base` equals 5, the displacement is 4 bytes for `mod_f` = 0, 1 byte for `mod_f` = 1 and 4 bytes for `mod_f` = 2. For any other base, the R3 rule for the given `mod_f` applies, with 0 bytes for `mod_f` = 0.
- R7: Displacement bytes arrive least significant first. A 1-byte displacement is sign-extended to 16 bits in 16-bit mode, with `disp[31:16]` = 0, and to 32 bits otherwise. Longer displacements are zero-extended.
- R8: `total_len` equals 1 + `has_sib` + `disp_len`. `done` is high for exactly the one cycle after the clock edge that accepts the last byte. `in_ready` is high only between `start` and that last byte. After reset, `in_ready` and `done` are 0.
- R9: `addr_mode` values 2 and 3 (64-bit) follow exactly the 32-bit rules. Stalls on `in_valid` do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode; accepted in ST_IDLE |
| addr_mode | input | 2 | 0 = 16-bit, 1 = 32-bit, 2/3 = 64-bit addressing |
| rex_r | input | 1 | Prefix extension for reg |
| rex_x | input | 1 | Prefix extension for index |
| rex_b | input | 1 | Prefix extension for rm/base |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Decoder takes a byte this cycle |
| done | output | 1 | One-cycle pulse: outputs complete |
| mod_f | output | 2 | Mode field |
| reg_f | output | 4 | Extended reg field |
| rm_f | output | 4 | Extended rm field |
| is_reg | output | 1 | Operand is a register |
| has_sib | output | 1 | Index byte was read |
| sib_scale | output | 2 | Scale field |
| sib_index | output | 4 | Extended index field |
| sib_base | output | 4 | Extended base field |
| disp | output | 32 | Assembled displacement |
| disp_len | output | 3 | Displacement byte count |
| total_len | output | 3 | Bytes consumed |

## Verification
Most internal errors change how many bytes the block consumes. A wrong length decision or a wrong state transition therefore moves the `done` pulse earlier or later than the reference model expects. It also drops `in_ready` too soon or holds it too long. Because `done` and `in_ready` are compared on every clock, such an error shows within one cycle of the first affected byte. A wrong field split, a misplaced prefix bit or a wrong extension leaves the timing intact. Those errors show only in the values sampled in the `done` cycle.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MODRM = 2'd1,
        ST_SIB   = 2'd2,
        ST_DISP  = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic [1:0] mod_v;
        logic [3:0] reg_v;
        logic [3:0] rm_v;
        logic       is_reg;
        logic       sib_next;
        logic [2:0] disp_len;
    } modrm_info_t;

    typedef struct packed {
        logic [1:0] scale;
        logic [3:0] index;
        logic [3:0] base;
        logic [2:0] disp_len;
    } sib_info_t;

endpackage

// File: rtl/modrm_split.sv
module modrm_split
    import modrm_pkg::*;
(
    input  logic [7:0]  byte_i,
    input  logic        narrow_i,
    input  logic        rex_r_i,
    input  logic        rex_b_i,
    output modrm_info_t info_o
);
    logic [1:0] md;
    logic [2:0] lo_rm;
    logic       direct;

    always_comb begin
        md     = byte_i[7:6];
        lo_rm  = byte_i[2:0];
        direct = (md == 2'd0) && (lo_rm == 3'd5);
        info_o.mod_v    = md;
        info_o.is_reg   = (md == 2'd3);
        info_o.sib_next = 1'b0;
        info_o.disp_len = 3'd0;
        if (narrow_i) begin
            info_o.reg_v = {1'b0, byte_i[5:3]};
            info_o.rm_v  = {1'b0, lo_rm};
            unique case (md)
                2'd0:    info_o.disp_len = (lo_rm == 3'd6) ? 3'd2 : 3'd0;
                2'd1:    info_o.disp_len = 3'd1;
                2'd2:    info_o.disp_len = 3'd2;
                default: info_o.disp_len = 3'd0;
            endcase
        end else begin
            info_o.reg_v    = {rex_r_i, byte_i[5:3]};
            info_o.sib_next = (md != 2'd3) && (lo_rm == 3'd4);
            info_o.rm_v     = {(!direct && !info_o.sib_next) ? rex_b_i : 1'b0, lo_rm};
            unique case (md)
                2'd0:    info_o.disp_len = direct ? 3'd4 : 3'd0;
                2'd1:    info_o.disp_len = 3'd1;
                2'd2:    info_o.disp_len = 3'd4;
                default: info_o.disp_len = 3'd0;
            endcase
        end
    end
endmodule

// File: rtl/sib_split.sv
module sib_split
    import modrm_pkg::*;
(
    input  logic [7:0] byte_i,
    input  logic [1:0] mod_i,
    input  logic       rex_x_i,
    input  logic       rex_b_i,
    output sib_info_t  info_o
);
    always_comb begin
        info_o.scale = byte_i[7:6];
        info_o.index = {rex_x_i, byte_i[5:3]};
        info_o.base  = {rex_b_i, byte_i[2:0]};
        unique case (mod_i)
            2'd0:    info_o.disp_len = (info_o.base == 4'd5) ? 3'd4 : 3'd0;
            2'd1:    info_o.disp_len = 3'd1;
            2'd2:    info_o.disp_len = 3'd4;
            default: info_o.disp_len = 3'd0;
        endcase
    end
endmodule

// File: rtl/disp_asm.sv
module disp_asm #(
    parameter int DISP_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      wr_en_i,
    input  logic [$clog2(DISP_W/8)-1:0] wr_idx_i,
    input  logic [7:0]                wr_byte_i,
    input  logic [2:0]                len_i,
    input  logic                      narrow_i,
    output logic [DISP_W-1:0]         disp_o
);
    localparam int NB     = DISP_W / 8;
    localparam int IDX_W  = $clog2(NB);
    localparam int HALF_W = DISP_W / 2;

    logic [DISP_W-1:0] raw;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= 8'h00;
            else if (clear_i)
                q <= 8'h00;
            else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
                q <= wr_byte_i;
        end
        assign raw[g*8 +: 8] = q;
    end

    always_comb begin
        disp_o = raw;
        if (len_i == 3'd1) begin
            if (narrow_i)
                disp_o = {{HALF_W{1'b0}}, {(HALF_W-8){raw[7]}}, raw[7:0]};
            else
                disp_o = {{(DISP_W-8){raw[7]}}, raw[7:0]};
        end
    end
endmodule

// File: rtl/modrm_decoder.sv
module modrm_decoder
    import modrm_pkg::*;
#(
    parameter int DISP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        addr_mode,
    input  logic              rex_r,
    input  logic              rex_x,
    input  logic              rex_b,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              done,
    output logic [1:0]        mod_f,
    output logic [3:0]        reg_f,
    output logic [3:0]        rm_f,
    output logic              is_reg,
    output logic              has_sib,
    output logic [1:0]        sib_scale,
    output logic [3:0]        sib_index,
    output logic [3:0]        sib_base,
    output logic [DISP_W-1:0] disp,
    output logic [2:0]        disp_len,
    output logic [2:0]        total_len
);
    localparam int NB    = DISP_W / 8;
    localparam int IDX_W = $clog2(NB);

    dec_state_e  state_q, state_d;
    modrm_info_t mi;
    sib_info_t   si;

    logic       narrow_q, rex_r_q, rex_x_q, rex_b_q;
    logic [2:0] idx_q, total_q, dlen_q;
    logic       done_q, fire, finish, launch;

    assign in_ready = (state_q != ST_IDLE);
    assign fire     = in_valid && in_ready;
    assign launch   = (state_q == ST_IDLE) && start;
    assign finish   = fire && (state_d == ST_IDLE);

    modrm_split u_modrm (
        .byte_i  (in_byte),
        .narrow_i(narrow_q),
        .rex_r_i (rex_r_q),
        .rex_b_i (rex_b_q),
        .info_o  (mi)
    );

    sib_split u_sib (
        .byte_i (in_byte),
        .mod_i  (mod_f),
        .rex_x_i(rex_x_q),
        .rex_b_i(rex_b_q),
        .info_o (si)
    );

    disp_asm #(.DISP_W(DISP_W)) u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (launch),
        .wr_en_i  (fire && (state_q == ST_DISP)),
        .wr_idx_i (idx_q[IDX_W-1:0]),
        .wr_byte_i(in_byte),
        .len_i    (dlen_q),
        .narrow_i (narrow_q),
        .disp_o   (disp)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_MODRM;
            ST_MODRM: if (fire) begin
                if (mi.sib_next)               state_d = ST_SIB;
                else if (mi.disp_len != 3'd0)  state_d = ST_DISP;
                else                           state_d = ST_IDLE;
            end
            ST_SIB:   if (fire) state_d = (si.disp_len != 3'd0) ? ST_DISP : ST_IDLE;
            ST_DISP:  if (fire && (idx_q == dlen_q - 3'd1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            narrow_q <= 1'b0; rex_r_q <= 1'b0; rex_x_q <= 1'b0; rex_b_q <= 1'b0;
            idx_q <= '0; total_q <= '0; dlen_q <= '0; done_q <= 1'b0;
            mod_f <= '0; reg_f <= '0; rm_f <= '0; is_reg <= 1'b0; has_sib <= 1'b0;
            sib_scale <= '0; sib_index <= '0; sib_base <= '0;
        end else begin
            done_q <= finish;
            if (launch) begin
                narrow_q  <= (addr_mode == 2'd0);
                rex_r_q   <= rex_r;
                rex_x_q   <= rex_x;
                rex_b_q   <= rex_b;
                idx_q     <= '0;
                total_q   <= '0;
                dlen_q    <= '0;
                has_sib   <= 1'b0;
                sib_scale <= '0;
                sib_index <= '0;
                sib_base  <= '0;
            end
            if (fire) total_q <= total_q + 3'd1;
            if (fire && state_q == ST_MODRM) begin
                mod_f   <= mi.mod_v;
                reg_f   <= mi.reg_v;
                rm_f    <= mi.rm_v;
                is_reg  <= mi.is_reg;
                has_sib <= mi.sib_next;
                dlen_q  <= mi.sib_next ? 3'd0 : mi.disp_len;
            end
            if (fire && state_q == ST_SIB) begin
                sib_scale <= si.scale;
                sib_index <= si.index;
                sib_base  <= si.base;
                dlen_q    <= si.disp_len;
            end
            if (fire && state_q == ST_DISP) idx_q <= idx_q + 3'd1;
        end
    end

    assign done      = done_q;
    assign disp_len  = dlen_q;
    assign total_len = total_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R8
    done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !in_ready);
    // R8
    total_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (total_len == 3'd1 + {2'b00, has_sib} + disp_len));
    // R5
    sib_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && has_sib) |-> (!is_reg && rm_f == 4'd4));
    // R2
    narrow_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && narrow_q) |-> (!has_sib && disp_len != 3'd4));
endmodule

// File: tb/modrm_decoder_tb.sv
module modrm_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] addr_mode = 2'd1;
    logic rex_r = 1'b0, rex_x = 1'b0, rex_b = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_ready, done, is_reg, has_sib;
    logic [1:0] mod_f, sib_scale;
    logic [3:0] reg_f, rm_f, sib_index, sib_base;
    logic [31:0] disp;
    logic [2:0] disp_len, total_len;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;
    logic [7:0] stim[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    modrm_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_mode(addr_mode),
        .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready), .done(done),
        .mod_f(mod_f), .reg_f(reg_f), .rm_f(rm_f), .is_reg(is_reg), .has_sib(has_sib),
        .sib_scale(sib_scale), .sib_index(sib_index), .sib_base(sib_base),
        .disp(disp), .disp_len(disp_len), .total_len(total_len)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // Reference model: parses the queued bytes, then drives them with gaps
    // and compares in_ready/done every cycle and all fields in the done cycle.
    task automatic run_case(string req, int am, bit r, bit x, bit b, int gap);
        int a16, md, rg, rmv, rmf, sib, dl, sc, ix, bs, tot, p;
        longint dv;
        a16 = (am == 0);
        md = stim[0] >> 6; rg = (stim[0] >> 3) & 7; rmv = stim[0] & 7;
        sib = 0; sc = 0; ix = 0; bs = 0; rmf = rmv; dl = 0;
        if (a16) begin
            if (md == 0) dl = (rmv == 6) ? 2 : 0;
            else if (md == 1) dl = 1;
            else if (md == 2) dl = 2;
        end else begin
            rg = rg + (r ? 8 : 0);
            if (md == 3) rmf = rmv + (b ? 8 : 0);
            else if (md == 0 && rmv == 5) dl = 4;
            else if (rmv == 4) begin
                sib = 1;
                sc = stim[1] >> 6;
                ix = ((stim[1] >> 3) & 7) + (x ? 8 : 0);
                bs = (stim[1] & 7) + (b ? 8 : 0);
                if (md == 1) dl = 1;
                else if (md == 2 || bs == 5) dl = 4;
            end else begin
                rmf = rmv + (b ? 8 : 0);
                dl = (md == 1) ? 1 : (md == 2) ? 4 : 0;
            end
        end
        tot = 1 + sib + dl;
        p = 1 + sib;
        dv = 0;
        for (int k = 0; k < dl; k++) dv = dv + (longint'(stim[p+k]) << (8*k));
        if (dl == 1 && stim[p][7]) dv = dv + (a16 ? 64'hFF00 : 64'hFFFFFF00);

        @(negedge clk);
        addr_mode = am[1:0]; rex_r = r; rex_x = x; rex_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < tot; i++) begin
            for (int g = 0; g < gap; g++) begin
                chk("R8", "ready in gap", in_ready, 1);
                chk("R9", "done in gap", done, 0);
                @(negedge clk);
            end
            chk("R8", "ready before byte", in_ready, 1);
            in_valid = 1'b1; in_byte = stim[i];
            @(negedge clk);
            in_valid = 1'b0;
            chk("R8", "done timing", done, (i == tot - 1) ? 1 : 0);
        end
        chk("R8", "ready after last", in_ready, 0);
        chk("R1", "mod", mod_f, md);
        chk("R4", "reg", reg_f, rg);
        chk("R4", "rm", rm_f, rmf);
        chk("R1", "is_reg", is_reg, (md == 3));
        chk("R5", "has_sib", has_sib, sib);
        if (sib) begin
            chk("R5", "scale", sib_scale, sc);
            chk("R5", "index", sib_index, ix);
            chk("R6", "base", sib_base, bs);
        end
        chk(req, "disp_len", disp_len, dl);
        chk("R7", "disp", disp, dv);
        chk("R8", "total", total_len, tot);
        @(negedge clk);
        chk("R8", "done one cycle", done, 0);
        stim.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8", "reset ready", in_ready, 0);
        chk("R8", "reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "idle ready", in_ready, 0);

        // R1 R4: register form with rex_b, 32-bit
        stim = '{8'hD2};                       run_case("R3", 1, 1, 0, 1, 0);
        // R3: absolute 32-bit displacement, rm not extended
        stim = '{8'h05, 8'h78, 8'h56, 8'h34, 8'h12}; run_case("R3", 1, 0, 0, 1, 1);
        // R5 R7: index byte, 1-byte negative displacement
        stim = '{8'h44, 8'h99, 8'h80};         run_case("R7", 1, 0, 1, 0, 0);
        // R6: base 5 with mod 0 gives 4 bytes
        stim = '{8'h04, 8'h25, 8'hEF, 8'hBE, 8'hAD, 8'hDE}; run_case("R6", 1, 0, 0, 0, 2);
        // R6: base 13 with mod 0 gives none
        stim = '{8'h0C, 8'h25};                run_case("R6", 1, 1, 1, 1, 0);
        // R6: base 5 mod 1 gives 1 byte
        stim = '{8'h44, 8'h05, 8'h7F};         run_case("R6", 1, 0, 0, 0, 0);
        // R2: 16-bit absolute form, rex ignored
        stim = '{8'h1E, 8'hEF, 8'hBE};         run_case("R2", 0, 1, 1, 1, 1);
        // R2 R7: 16-bit mod 1, rm 4 reads no index byte, sign-extend to 16
        stim = '{8'h64, 8'hF0};                run_case("R2", 0, 0, 0, 0, 0);
        // R2: 16-bit mod 2
        stim = '{8'hBF, 8'h34, 8'h12};         run_case("R2", 0, 0, 0, 0, 0);
        // R2: 16-bit mod 0 non-6, no displacement
        stim = '{8'h03};                       run_case("R2", 0, 0, 0, 0, 0);
        // R9: 64-bit mode follows 32-bit rules
        stim = '{8'h89, 8'h01, 8'h02, 8'h03, 8'h84}; run_case("R9", 2, 1, 0, 1, 1);
        // R9: mode 3 with index byte and mod 2
        stim = '{8'h84, 8'hE5, 8'h11, 8'h22, 8'h33, 8'h44}; run_case("R9", 3, 0, 1, 0, 0);
        // R3: mod 0 plain register base, no displacement
        stim = '{8'h01};                       run_case("R3", 1, 0, 0, 1, 0);

        finish_run();
    end
endmodule